// File: doc/BRIEF.md
# Interleaved DRAM Address Router

This block decides which memory node owns a 40-bit physical address. It holds eight programmable regions. Each region has a lower and an upper bound on the address bits 39:24, so regions are sized in 16 MB steps. Each region also has separate read and write enables and a node number. A request presents an address and a read/write type. One clock later the block reports whether a region claimed the address, the node that owns it, and which region matched.

Several nodes can split one address range by interleaving. A 3-bit interleave code in the lower-bound register selects which of address bits 14:12 take part. A 3-bit select value in the upper-bound register gives the value those bits must have for that region to claim the address. To spread one range over 2, 4 or 8 nodes, software programs several regions with the same bounds and different select values.

Software programs the regions through a single-cycle write port. The enables sit in the lower-bound word. Software therefore writes the upper-bound word first, and the region only becomes active once its lower-bound word is written.

Top module: `dram_route_top`

## Requirements
- R1: A request with `req_valid` high produces `rsp_valid` high on the next clock edge only. When `req_valid` is low, `rsp_valid` is low one clock later, and `rsp_hit`, `rsp_node` and `rsp_region` hold their previous values.
- R2: Lower-bound word bit 0 enables reads (`req_write`=0) and bit 1 enables writes (`req_write`=1). A region never matches a request whose direction it does not enable.
- R3: A region matches only when lower <= A[39:24] <= upper, inclusive at both ends. The lower bound is in bits 31:16 of the lower-bound word and the upper bound is in bits 31:16 of the upper-bound word.
- R4: On a hit, `rsp_node` equals bits 2:0 of the matching region's upper-bound word.
- R5: The interleave code is in bits 10:8 of the lower-bound word, and the select value is in bits 10:8 of the upper-bound word. Code 001 requires A[12] to equal select bit 0. Code 011 requires A[13:12] to equal select bits 1:0. Code 111 requires A[14:12] to equal the whole select value.
- R6: Every other interleave code (000, 010, 100, 101, 110) applies no interleave condition.
- R7: When several regions match, the lowest-numbered region wins, and `rsp_region` gives its index.
- R8: On a miss, `rsp_hit`, `rsp_node` and `rsp_region` are all zero.
- R9: After reset every region is disabled and all response outputs are zero.
- R10: A region whose upper-bound word alone has been written stays inactive.
- R11: A write takes effect for requests presented from the next clock on. A request in the same cycle as a write is decoded against the old contents. `cfg_sel` picks the region, and `cfg_is_limit`=1 selects the upper-bound word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Region index of the write |
| cfg_is_limit | input | 1 | 1 = upper-bound word, 0 = lower-bound word |
| cfg_data | input | 32 | Write data |
| req_valid | input | 1 | Request present |
| req_addr | input | 40 | Physical address |
| req_write | input | 1 | 1 = write request, 0 = read request |
| rsp_valid | output | 1 | Result strobe, one clock after the request |
| rsp_hit | output | 1 | A region claimed the address |
| rsp_node | output | 3 | Owning node, zero on a miss |
| rsp_region | output | 3 | Index of the winning region, zero on a miss |

## Verification
The checker assumes that `req_valid` and the write port are driven only with settled values, and that reset starts with every region disabled. From these it derives its rules:
- a hit can only follow a lower-bound write that set an enable bit;
- a miss always reports zeros;
- the response fields hold between requests.

The directed stimulus keeps to this. Inputs change on the falling clock edge. Every region is programmed upper word first. Address bits that neither the range nor the interleave compare are held at zero, except where a test deliberately varies A[14:12]. One test places a write and a request in the same cycle on purpose, to observe the ordering rule.

// File: rtl/dram_route_pkg.sv
package dram_route_pkg;
  localparam int NODE_W       = 3;
  localparam int IL_W         = 3;
  localparam int IL_ADDR_LSB  = 12;
  localparam int CFG_W        = 32;
  localparam int RD_EN_BIT    = 0;
  localparam int WR_EN_BIT    = 1;
  localparam int IL_FIELD_LSB = 8;
  localparam int BOUND_LSB    = 16;

  typedef enum logic [IL_W-1:0] {
    IL_NONE = 3'b000,
    IL_TWO  = 3'b001,
    IL_FOUR = 3'b011,
    IL_EIGHT = 3'b111
  } il_code_e;

  // Address bits 14:12 that take part for a given code; unknown codes use none.
  function automatic logic [IL_W-1:0] il_mask(input logic [IL_W-1:0] code);
    case (code)
      IL_TWO:   il_mask = 3'b001;
      IL_FOUR:  il_mask = 3'b011;
      IL_EIGHT: il_mask = 3'b111;
      default:  il_mask = 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/dram_route_regs.sv
module dram_route_regs
  import dram_route_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int RANGE_W     = 16,
  parameter int IDX_W       = 3
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cfg_wr,
  input  logic [IDX_W-1:0]                    cfg_sel,
  input  logic                                cfg_is_limit,
  input  logic [CFG_W-1:0]                    cfg_data,
  output logic [NUM_REGIONS-1:0]              rd_ok,
  output logic [NUM_REGIONS-1:0]              wr_ok,
  output logic [NUM_REGIONS-1:0][IL_W-1:0]    il_code,
  output logic [NUM_REGIONS-1:0][IL_W-1:0]    il_sel,
  output logic [NUM_REGIONS-1:0][NODE_W-1:0]  node,
  output logic [NUM_REGIONS-1:0][RANGE_W-1:0] lo,
  output logic [NUM_REGIONS-1:0][RANGE_W-1:0] hi
);
  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{cfg_data[IL_FIELD_LSB-1:NODE_W],
                             cfg_data[BOUND_LSB-1:IL_FIELD_LSB+IL_W]};

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    logic base_we, limit_we;
    assign base_we  = cfg_wr && !cfg_is_limit && (cfg_sel == IDX_W'(g));
    assign limit_we = cfg_wr &&  cfg_is_limit && (cfg_sel == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rd_ok[g]   <= 1'b0;
        wr_ok[g]   <= 1'b0;
        il_code[g] <= '0;
        lo[g]      <= '0;
      end else if (base_we) begin
        rd_ok[g]   <= cfg_data[RD_EN_BIT];
        wr_ok[g]   <= cfg_data[WR_EN_BIT];
        il_code[g] <= cfg_data[IL_FIELD_LSB +: IL_W];
        lo[g]      <= cfg_data[BOUND_LSB +: RANGE_W];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        node[g]   <= '0;
        il_sel[g] <= '0;
        hi[g]     <= '0;
      end else if (limit_we) begin
        node[g]   <= cfg_data[NODE_W-1:0];
        il_sel[g] <= cfg_data[IL_FIELD_LSB +: IL_W];
        hi[g]     <= cfg_data[BOUND_LSB +: RANGE_W];
      end
    end
  end
endmodule

// File: rtl/dram_route_match.sv
module dram_route_match
  import dram_route_pkg::*;
#(
  parameter int RANGE_W = 16
) (
  input  logic [RANGE_W-1:0] a_top,
  input  logic [IL_W-1:0]    a_il,
  input  logic               is_write,
  input  logic               rd_ok,
  input  logic               wr_ok,
  input  logic [IL_W-1:0]    il_code,
  input  logic [IL_W-1:0]    il_sel,
  input  logic [RANGE_W-1:0] lo,
  input  logic [RANGE_W-1:0] hi,
  output logic               hit
);
  logic            dir_ok, in_range, il_ok;
  logic [IL_W-1:0] mask;

  always_comb begin
    dir_ok   = is_write ? wr_ok : rd_ok;
    in_range = (a_top >= lo) && (a_top <= hi);
    mask     = il_mask(il_code);
    il_ok    = ((a_il ^ il_sel) & mask) == '0;
    hit      = dir_ok && in_range && il_ok;
  end
endmodule

// File: rtl/dram_route_prio.sv
module dram_route_prio
  import dram_route_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int IDX_W       = 3
) (
  input  logic [NUM_REGIONS-1:0]             match,
  input  logic [NUM_REGIONS-1:0][NODE_W-1:0] node,
  output logic                               any,
  output logic [IDX_W-1:0]                   idx,
  output logic [NODE_W-1:0]                  sel_node
);
  // Walk from the top down so the lowest matching index is written last.
  always_comb begin
    any      = 1'b0;
    idx      = '0;
    sel_node = '0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (match[i]) begin
        any      = 1'b1;
        idx      = IDX_W'(i);
        sel_node = node[i];
      end
    end
  end
endmodule

// File: rtl/dram_route_top.sv
module dram_route_top
  import dram_route_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 40,
  parameter int GRAN_LSB    = 24,
  localparam int RANGE_W    = ADDR_W - GRAN_LSB,
  localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [IDX_W-1:0]  cfg_sel,
  input  logic              cfg_is_limit,
  input  logic [CFG_W-1:0]  cfg_data,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [NODE_W-1:0] rsp_node,
  output logic [IDX_W-1:0]  rsp_region
);
  logic [NUM_REGIONS-1:0]              rd_ok, wr_ok, match;
  logic [NUM_REGIONS-1:0][IL_W-1:0]    il_code, il_sel;
  logic [NUM_REGIONS-1:0][NODE_W-1:0]  node;
  logic [NUM_REGIONS-1:0][RANGE_W-1:0] lo, hi;
  logic [RANGE_W-1:0]                  a_top;
  logic [IL_W-1:0]                     a_il;
  logic                                any_hit;
  logic [IDX_W-1:0]                    win_idx;
  logic [NODE_W-1:0]                   win_node;

  logic unused_addr;
  assign unused_addr = ^{req_addr[GRAN_LSB-1:IL_ADDR_LSB+IL_W],
                         req_addr[IL_ADDR_LSB-1:0]};

  assign a_top = req_addr[ADDR_W-1:GRAN_LSB];
  assign a_il  = req_addr[IL_ADDR_LSB +: IL_W];

  dram_route_regs #(
    .NUM_REGIONS(NUM_REGIONS), .RANGE_W(RANGE_W), .IDX_W(IDX_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_is_limit(cfg_is_limit), .cfg_data(cfg_data),
    .rd_ok(rd_ok), .wr_ok(wr_ok), .il_code(il_code), .il_sel(il_sel),
    .node(node), .lo(lo), .hi(hi)
  );

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
    dram_route_match #(.RANGE_W(RANGE_W)) u_match (
      .a_top(a_top), .a_il(a_il), .is_write(req_write),
      .rd_ok(rd_ok[g]), .wr_ok(wr_ok[g]), .il_code(il_code[g]),
      .il_sel(il_sel[g]), .lo(lo[g]), .hi(hi[g]), .hit(match[g])
    );
  end

  dram_route_prio #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)) u_prio (
    .match(match), .node(node), .any(any_hit), .idx(win_idx), .sel_node(win_node)
  );

  // Response next-state.
  logic              hit_d;
  logic [NODE_W-1:0] node_d;
  logic [IDX_W-1:0]  region_d;

  always_comb begin
    hit_d    = rsp_hit;
    node_d   = rsp_node;
    region_d = rsp_region;
    if (req_valid) begin
      hit_d    = any_hit;
      node_d   = any_hit ? win_node : '0;
      region_d = any_hit ? win_idx  : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_node   <= '0;
      rsp_region <= '0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_hit    <= hit_d;
      rsp_node   <= node_d;
      rsp_region <= region_d;
    end
  end
endmodule

// File: rtl/dram_route_chk.sv
module dram_route_chk
  import dram_route_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic              cfg_is_limit,
  input logic [CFG_W-1:0]  cfg_data,
  input logic              req_valid,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [NODE_W-1:0] rsp_node,
  input logic [IDX_W-1:0]  rsp_region
);
  // Set once any lower-bound word with an enable bit has been accepted.
  logic en_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_seen <= 1'b0;
    else if (cfg_wr && !cfg_is_limit && (cfg_data[WR_EN_BIT:RD_EN_BIT] != 2'b00))
      en_seen <= 1'b1;
  end

  p_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(rsp_hit) && $stable(rsp_node) && $stable(rsp_region)));
  p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_node == '0 && rsp_region == '0));
  p_need_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> $past(en_seen));
endmodule

bind dram_route_top dram_route_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_is_limit(cfg_is_limit),
  .cfg_data(cfg_data), .req_valid(req_valid), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .rsp_node(rsp_node), .rsp_region(rsp_region)
);

// File: tb/sim_dram_route_top.sv
module sim_dram_route_top;
  logic        clk, rst_n;
  logic        cfg_wr, cfg_is_limit, req_valid, req_write;
  logic [2:0]  cfg_sel;
  logic [31:0] cfg_data;
  logic [39:0] req_addr;
  logic        rsp_valid, rsp_hit;
  logic [2:0]  rsp_node, rsp_region;
  int checks = 0, failures = 0;
  bit done = 0;

  dram_route_top u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_is_limit(cfg_is_limit), .cfg_data(cfg_data), .req_valid(req_valid),
    .req_addr(req_addr), .req_write(req_write), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_node(rsp_node), .rsp_region(rsp_region)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  function automatic logic [31:0] lower_word(input logic [15:0] b, input logic [2:0] code,
                                             input logic we, input logic re);
    return {b, 5'b0, code, 6'b0, we, re};
  endfunction
  function automatic logic [31:0] upper_word(input logic [15:0] b, input logic [2:0] sel,
                                             input logic [2:0] nd);
    return {b, 5'b0, sel, 5'b0, nd};
  endfunction
  function automatic logic [39:0] mk(input logic [15:0] top, input logic [2:0] il);
    return {top, 9'b0, il, 12'h000};
  endfunction

  task automatic put(input logic [2:0] idx, input logic lim, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_sel = idx; cfg_is_limit = lim; cfg_data = d;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic expect_rsp(input string tag, input logic eh, input logic [2:0] en,
                            input logic [2:0] er);
    checks++;
    if (rsp_valid !== 1'b1 || rsp_hit !== eh || rsp_node !== en || rsp_region !== er) begin
      failures++;
      $display("FAIL %s: got v=%b hit=%b node=%0d region=%0d, expected v=1 hit=%b node=%0d region=%0d",
               tag, rsp_valid, rsp_hit, rsp_node, rsp_region, eh, en, er);
    end
  endtask

  task automatic ask(input string tag, input logic [39:0] a, input logic w,
                     input logic eh, input logic [2:0] en, input logic [2:0] er);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_write = w;
    @(negedge clk);
    req_valid = 0;
    expect_rsp(tag, eh, en, er);
  endtask

  task automatic t_reset();
    checks++;
    if (rsp_valid !== 0 || rsp_hit !== 0 || rsp_node !== 0 || rsp_region !== 0) begin
      failures++;
      $display("FAIL R9 reset outputs: got v=%b hit=%b node=%0d region=%0d, expected all 0",
               rsp_valid, rsp_hit, rsp_node, rsp_region);
    end
    ask("R9 no region active after reset", mk(16'h0000, 0), 0, 0, 0, 0);
  endtask

  task automatic t_limit_then_base();
    put(0, 1, upper_word(16'h0010, 3'b000, 3'd5));
    ask("R10 upper word alone inactive", mk(16'h0005, 0), 0, 0, 0, 0);
    put(0, 0, lower_word(16'h0002, 3'b000, 0, 1));
    ask("R3 lower bound inclusive / R4 node", mk(16'h0002, 0), 0, 1, 5, 0);
    ask("R3 upper bound inclusive", mk(16'h0010, 0), 0, 1, 5, 0);
    ask("R3 above upper R8 miss zeros", mk(16'h0011, 0), 0, 0, 0, 0);
    ask("R3 below lower", mk(16'h0001, 0), 0, 0, 0, 0);
    ask("R2 write blocked on read-only region", mk(16'h0005, 0), 1, 0, 0, 0);
  endtask

  task automatic t_direction();
    put(1, 1, upper_word(16'h0100, 3'b000, 3'd3));
    put(1, 0, lower_word(16'h0100, 3'b000, 1, 0));
    ask("R2 read blocked on write-only region", mk(16'h0100, 0), 0, 0, 0, 0);
    ask("R2 write allowed", mk(16'h0100, 0), 1, 1, 3, 1);
  endtask

  task automatic t_priority();
    put(2, 1, upper_word(16'h0300, 3'b000, 3'd2));
    put(2, 0, lower_word(16'h0200, 3'b000, 1, 1));
    put(4, 1, upper_word(16'h0400, 3'b000, 3'd4));
    put(4, 0, lower_word(16'h0250, 3'b000, 1, 1));
    ask("R7 overlap lowest index wins", mk(16'h0260, 0), 0, 1, 2, 2);
    ask("R7 only higher region", mk(16'h0350, 0), 1, 1, 4, 4);
  endtask

  task automatic t_interleave();
    put(5, 1, upper_word(16'h1FFF, 3'b000, 3'd1));
    put(5, 0, lower_word(16'h1000, 3'b001, 1, 1));
    put(6, 1, upper_word(16'h1FFF, 3'b001, 3'd6));
    put(6, 0, lower_word(16'h1000, 3'b001, 1, 1));
    ask("R5 two-way A12=0", mk(16'h1800, 3'b110), 0, 1, 1, 5);
    ask("R5 two-way A12=1", mk(16'h1800, 3'b111), 0, 1, 6, 6);
    put(7, 1, upper_word(16'h2000, 3'b101, 3'd7));
    put(7, 0, lower_word(16'h2000, 3'b111, 1, 1));
    ask("R5 eight-way equal", mk(16'h2000, 3'b101), 0, 1, 7, 7);
    ask("R5 eight-way A12 differs", mk(16'h2000, 3'b100), 0, 0, 0, 0);
    ask("R5 eight-way A14 differs", mk(16'h2000, 3'b001), 0, 0, 0, 0);
    put(3, 1, upper_word(16'h3000, 3'b010, 3'd2));
    put(3, 0, lower_word(16'h3000, 3'b011, 1, 1));
    ask("R5 four-way equal, A14 ignored", mk(16'h3000, 3'b110), 0, 1, 2, 3);
    ask("R5 four-way differs", mk(16'h3000, 3'b011), 0, 0, 0, 0);
  endtask

  task automatic t_odd_code();
    put(0, 1, upper_word(16'h0010, 3'b111, 3'd5));
    put(0, 0, lower_word(16'h0002, 3'b010, 0, 1));
    ask("R6 code 010 no interleave", mk(16'h0005, 3'b000), 0, 1, 5, 0);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    cfg_wr = 1; cfg_sel = 1; cfg_is_limit = 0; cfg_data = 32'h0;
    req_valid = 1; req_addr = mk(16'h0100, 0); req_write = 1;
    @(negedge clk);
    cfg_wr = 0; req_valid = 0;
    expect_rsp("R11 same-cycle request sees old region", 1, 3, 1);
    ask("R11 write visible next request", mk(16'h0100, 0), 1, 0, 0, 0);
  endtask

  task automatic t_hold();
    ask("R1 setup hit", mk(16'h0260, 0), 0, 1, 2, 2);
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 0 || rsp_hit !== 1 || rsp_node !== 2 || rsp_region !== 2) begin
      failures++;
      $display("FAIL R1 idle hold: got v=%b hit=%b node=%0d region=%0d, expected v=0 hit=1 node=2 region=2",
               rsp_valid, rsp_hit, rsp_node, rsp_region);
    end
  endtask

  initial begin
    rst_n = 0; cfg_wr = 0; cfg_sel = 0; cfg_is_limit = 0; cfg_data = 0;
    req_valid = 0; req_addr = 0; req_write = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_limit_then_base();
    t_direction();
    t_priority();
    t_interleave();
    t_odd_code();
    t_same_cycle();
    t_hold();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got no completion, expected end of tests");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule